// File: doc/BRIEF.md
# Three-Port Wormhole Packet Router

The router sits between three link ports and a local sink of a network node. Characters move over valid/ready handshakes. Each character is nine bits wide. Bit 8 marks a delimiter. On a delimiter, bit 0 selects normal end (0) or error end (1), and all eight low bits pass through unchanged. Every link and the local sink have a programmable 8-bit address.

With routing on, the first character of a packet is read as its destination and then discarded. The body, up to and including its delimiter, is then steered to the link or to the local sink that the destination names. An output stays owned by one input until that input's delimiter has passed. A round-robin arbiter picks among inputs that contend for the same output. A destination that matches nothing is still delivered to the local sink, and it sets a sticky error flag that drives a maskable interrupt. With routing off, every packet goes to the local sink unmodified.

Top module: `wormhole_router`

## Requirements
- R1: With routing on, a header equal to the address of another link sends the packet body to that link's output.
- R2: A header equal to the local address sends the packet to the local output (index 3), even when a link has the same address.
- R3: The header character is removed; the body characters and the delimiter arrive at the output in order and unmodified.
- R4: A delimiter (bit 8 set) ends the packet whether bit 0 marks normal end (0) or error end (1).
- R5: A header that matches no address, including the receiving link's own address, sends the packet to the local output and sets the sticky error flag err_o.
- R6: irq_o is err_o gated by a mask bit written through mask_we_i/mask_wd_i; a one on err_clr_i clears err_o.
- R7: An output carries one packet at a time: characters of different inputs never interleave before a delimiter.
- R8: Inputs that request the same free output are served in rotating order, so three simultaneous requesters each get one packet before any gets a second.
- R9: When an output is not ready, the feeding input is stalled through in_ready_o; no character is lost or duplicated.
- R10: A delimiter directly after the header forms an empty packet that is delivered as the delimiter alone.
- R11: With routing off, packets go to the local output with no character removed, and err_o is not set.
- R12: After reset no output is valid, err_o is 0, and the mask is 0, so irq_o is 0.
- R13: With routing on, a delimiter in the header position is consumed and discarded without producing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_en_i | input | 1 | 1: header routing, 0: everything to local |
| link_addr_i | input | 24 | Link addresses, link k at bits 8k+7:8k |
| local_addr_i | input | 8 | Local sink address |
| in_valid_i | input | 3 | Per-link input character valid |
| in_data_i | input | 27 | Per-link input characters, link k at bits 9k+8:9k |
| in_ready_o | output | 3 | Per-link input accept |
| out_valid_o | output | 4 | Output valid, index 3 is the local sink |
| out_data_o | output | 36 | Output characters, output k at bits 9k+8:9k |
| out_ready_i | input | 4 | Output accept |
| mask_we_i | input | 1 | Write strobe for the interrupt mask |
| mask_wd_i | input | 1 | Mask value to write |
| err_clr_i | input | 1 | Write-one clear of the error flag |
| err_o | output | 1 | Sticky unmatched-destination flag |
| irq_o | output | 1 | Masked interrupt |

## Verification
Some properties are checked on every cycle. An input is never owned by two outputs at once. An owning arbiter keeps its owner until the delimiter passes. A stalled input holds its destination. The error flag holds until cleared, and the interrupt never fires without it. Other behaviours can only be shown by the bench's scenarios, against a queue model fed with tagged characters: which output each header selects, stripping of the header, the priority of the local address, that rotation among contenders is fair, that nothing is lost under random backpressure, empty packets, discarded leading delimiters, and the transparent mode.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
  typedef enum logic {ST_HDR, ST_BODY} in_state_e;
endpackage

// File: rtl/rtr_in_unit.sv
module rtr_in_unit
  import rtr_pkg::*;
#(
  parameter int NL   = 3,
  parameter int AW   = 8,
  parameter int PIDX = 0,
  localparam int NP  = NL + 1,
  localparam int PW  = $clog2(NP)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             route_en_i,
  input  logic [NL*AW-1:0] link_addr_i,
  input  logic [AW-1:0]    local_addr_i,
  input  logic             valid_i,
  input  logic [AW:0]      data_i,
  output logic             ready_o,
  input  logic             grant_i,
  input  logic             dst_ready_i,
  output logic [NP-1:0]    req_o,
  output logic [PW-1:0]    dest_o,
  output logic             miss_o
);
  localparam logic [PW-1:0] LOCAL = PW'(NL);

  in_state_e     state_q;
  logic [PW-1:0] dest_q, hit_dest;
  logic          hit_miss;

  // local address wins over link addresses; own link never matches
  always_comb begin
    hit_dest = LOCAL;
    hit_miss = 1'b1;
    for (int j = 0; j < NL; j++) begin
      if (j != PIDX && hit_miss && data_i[AW-1:0] == link_addr_i[j*AW +: AW]) begin
        hit_dest = PW'(j);
        hit_miss = 1'b0;
      end
    end
    if (data_i[AW-1:0] == local_addr_i) begin
      hit_dest = LOCAL;
      hit_miss = 1'b0;
    end
  end

  always_comb begin
    req_o = '0;
    if (state_q == ST_BODY) req_o[dest_q] = 1'b1;
  end

  assign ready_o = (state_q == ST_HDR) ? route_en_i : (grant_i & dst_ready_i);
  assign dest_o  = dest_q;
  assign miss_o  = (state_q == ST_HDR) & valid_i & route_en_i & ~data_i[AW] & hit_miss;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HDR;
      dest_q  <= '0;
    end else begin
      case (state_q)
        ST_HDR: if (valid_i) begin
          if (!route_en_i) begin
            state_q <= ST_BODY;
            dest_q  <= LOCAL;
          end else if (!data_i[AW]) begin
            state_q <= ST_BODY;
            dest_q  <= hit_dest;
          end
        end
        default: if (valid_i && ready_o && data_i[AW]) state_q <= ST_HDR;
      endcase
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BODY && valid_i && !ready_o) |=> (state_q == ST_BODY && $stable(dest_q)));

endmodule

// File: rtl/rtr_rr_arb.sv
module rtr_rr_arb #(
  parameter int NI  = 3,
  localparam int OW = $clog2(NI)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [NI-1:0] req_i,
  input  logic          last_i,
  output logic          busy_o,
  output logic [OW-1:0] owner_o
);
  logic          busy_q;
  logic [OW-1:0] owner_q, ptr_q, pick;
  logic          found;

  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    for (int k = 0; k < NI; k++) begin
      int idx;
      idx = int'(ptr_q) + k;
      if (idx >= NI) idx = idx - NI;
      if (!found && req_i[idx]) begin
        pick  = OW'(idx);
        found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (!busy_q) begin
      if (found) begin
        busy_q  <= 1'b1;
        owner_q <= pick;
      end
    end else if (last_i) begin
      busy_q <= 1'b0;
      ptr_q  <= (owner_q == OW'(NI-1)) ? '0 : owner_q + 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;

  assert_owner_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !last_i) |=> (busy_q && $stable(owner_q)));

endmodule

// File: rtl/wormhole_router.sv
module wormhole_router #(
  parameter int NL  = 3,
  parameter int AW  = 8,
  localparam int NP = NL + 1,
  localparam int CW = AW + 1,
  localparam int PW = $clog2(NP),
  localparam int OW = $clog2(NL)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             route_en_i,
  input  logic [NL*AW-1:0] link_addr_i,
  input  logic [AW-1:0]    local_addr_i,
  input  logic [NL-1:0]    in_valid_i,
  input  logic [NL*CW-1:0] in_data_i,
  output logic [NL-1:0]    in_ready_o,
  output logic [NP-1:0]    out_valid_o,
  output logic [NP*CW-1:0] out_data_o,
  input  logic [NP-1:0]    out_ready_i,
  input  logic             mask_we_i,
  input  logic             mask_wd_i,
  input  logic             err_clr_i,
  output logic             err_o,
  output logic             irq_o
);
  logic [NP-1:0] req     [NL];
  logic [PW-1:0] dest    [NL];
  logic [NP-1:0] own_map [NL];
  logic [NL-1:0] arb_req [NP];
  logic [OW-1:0] owner   [NP];
  logic [NL-1:0] miss, grant_in, dst_rdy;
  logic [NP-1:0] busy, last;
  logic          err_q, mask_q;

  always_comb begin
    for (int o = 0; o < NP; o++)
      for (int i = 0; i < NL; i++) begin
        arb_req[o][i] = req[i][o];
        own_map[i][o] = busy[o] && (owner[o] == OW'(i));
      end
  end

  for (genvar i = 0; i < NL; i++) begin : g_in
    assign grant_in[i] = own_map[i][dest[i]];
    assign dst_rdy[i]  = out_ready_i[dest[i]];

    rtr_in_unit #(.NL(NL), .AW(AW), .PIDX(i)) u_in (
      .clk_i, .rst_ni, .route_en_i, .link_addr_i, .local_addr_i,
      .valid_i     (in_valid_i[i]),
      .data_i      (in_data_i[i*CW +: CW]),
      .ready_o     (in_ready_o[i]),
      .grant_i     (grant_in[i]),
      .dst_ready_i (dst_rdy[i]),
      .req_o       (req[i]),
      .dest_o      (dest[i]),
      .miss_o      (miss[i])
    );

    assert_single_owner_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(own_map[i]));
  end

  for (genvar o = 0; o < NP; o++) begin : g_out
    rtr_rr_arb #(.NI(NL)) u_arb (
      .clk_i, .rst_ni,
      .req_i   (arb_req[o]),
      .last_i  (last[o]),
      .busy_o  (busy[o]),
      .owner_o (owner[o])
    );
    assign out_valid_o[o]           = busy[o] & in_valid_i[owner[o]];
    assign out_data_o[o*CW +: CW]   = in_data_i[int'(owner[o])*CW +: CW];
    assign last[o] = out_valid_o[o] & out_ready_i[o] & out_data_o[o*CW + AW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_q  <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      err_q <= (err_q & ~err_clr_i) | (|miss);
      if (mask_we_i) mask_q <= mask_wd_i;
    end
  end

  assign err_o = err_q;
  assign irq_o = err_q & mask_q;

  assert_err_sticky_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !err_clr_i) |=> err_o);
  assert_irq_needs_err_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> err_o);

endmodule

// File: tb/wormhole_router_test.sv
`timescale 1ns/1ps
module wormhole_router_test;
  localparam int NL = 3, NP = 4, AW = 8, CW = 9;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             route_en = 1'b1;
  logic [NL*AW-1:0] link_addr = {8'h33, 8'h22, 8'h11};
  logic [AW-1:0]    local_addr = 8'h44;
  logic [NL-1:0]    in_valid = '0, in_ready;
  logic [NL*CW-1:0] in_data = '0;
  logic [NP-1:0]    out_valid, out_ready = '1;
  logic [NP*CW-1:0] out_data;
  logic             mask_we = 1'b0, mask_wd = 1'b0, err_clr = 1'b0, err, irq;

  wormhole_router uut (
    .clk_i(clk), .rst_ni(rst_n), .route_en_i(route_en), .link_addr_i(link_addr),
    .local_addr_i(local_addr), .in_valid_i(in_valid), .in_data_i(in_data),
    .in_ready_o(in_ready), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_ready_i(out_ready), .mask_we_i(mask_we), .mask_wd_i(mask_wd),
    .err_clr_i(err_clr), .err_o(err), .irq_o(irq)
  );

  logic [CW-1:0] drv_q [NL][$];
  logic [CW-1:0] exp_q [NP][NL][$];
  int    lock_src [NP];
  int    start_log[$];
  int    n_chk = 0, n_err = 0, cyc = 0;
  bit    stall_en = 1'b0;
  string cur_req = "R12";

  task automatic chk(bit ok, string req, string what, int act, int expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int dest_of(int src, logic [7:0] h);
    if (h == local_addr) return 3;
    for (int j = 0; j < NL; j++)
      if (j != src && h == link_addr[j*AW +: AW]) return j;
    return 3;
  endfunction

  task automatic send(int src, logic [7:0] hdr, int n, bit eep);
    int d;
    logic [CW-1:0] c;
    d = route_en ? dest_of(src, hdr) : 3;
    drv_q[src].push_back({1'b0, hdr});
    if (!route_en) exp_q[d][src].push_back({1'b0, hdr});
    for (int k = 0; k < n; k++) begin
      c = {1'b0, 2'(src), 6'(k * 7 + int'(hdr))};
      drv_q[src].push_back(c);
      exp_q[d][src].push_back(c);
    end
    c = {1'b1, 2'(src), 5'b0, eep};
    drv_q[src].push_back(c);
    exp_q[d][src].push_back(c);
  endtask

  function automatic bit busy_any();
    for (int s = 0; s < NL; s++) begin
      if (drv_q[s].size() != 0) return 1'b1;
      for (int o = 0; o < NP; o++) if (exp_q[o][s].size() != 0) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic wait_idle();
    int t = 0;
    while (busy_any() && t < 4000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    chk(!busy_any(), cur_req, "undelivered or lost characters", int'(busy_any()), 0);
  endtask

  // drive at negedge, sample handshakes shortly before the next rising edge
  initial begin
    for (int o = 0; o < NP; o++) lock_src[o] = -1;
    forever begin
      @(negedge clk);
      for (int s = 0; s < NL; s++) begin
        in_valid[s] = drv_q[s].size() > 0;
        in_data[s*CW +: CW] = in_valid[s] ? drv_q[s][0] : '0;
      end
      for (int o = 0; o < NP; o++) out_ready[o] = stall_en ? ($urandom % 3 != 0) : 1'b1;
      #2;
      for (int o = 0; o < NP; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          logic [CW-1:0] c;
          int tg;
          c  = out_data[o*CW +: CW];
          tg = int'(c[7:6]);
          if (tg >= NL || exp_q[o][tg].size() == 0) begin
            chk(1'b0, cur_req, $sformatf("unexpected char at output %0d", o), int'(c), 0);
          end else begin
            chk(c == exp_q[o][tg][0], cur_req, $sformatf("char at output %0d", o),
                int'(c), int'(exp_q[o][tg][0]));
            void'(exp_q[o][tg].pop_front());
          end
          if (lock_src[o] >= 0)
            chk(tg == lock_src[o], "R7", $sformatf("interleave at output %0d", o), tg, lock_src[o]);
          else if (o == 3)
            start_log.push_back(tg);
          lock_src[o] = c[8] ? -1 : tg;
        end
      end
      for (int s = 0; s < NL; s++)
        if (in_valid[s] && in_ready[s]) void'(drv_q[s].pop_front());
      cyc++;
      if (cyc > 150000) begin
        n_err++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk(out_valid == '0, "R12", "out_valid after reset", int'(out_valid), 0);
    chk(err == 1'b0, "R12", "err after reset", int'(err), 0);
    chk(irq == 1'b0, "R12", "irq after reset", int'(irq), 0);

    cur_req = "R1";  // concurrent link-to-link routes, also R3 stripping
    send(0, 8'h22, 4, 1'b0);
    send(1, 8'h33, 5, 1'b0);
    send(2, 8'h11, 3, 1'b1);
    wait_idle();

    cur_req = "R4";  // error-end delimiter closes packet, next one follows
    send(1, 8'h11, 2, 1'b1);
    send(1, 8'h33, 2, 1'b0);
    wait_idle();

    cur_req = "R2";
    send(0, 8'h44, 3, 1'b0);
    @(negedge clk);
    wait_idle();
    local_addr = 8'h22;  // local address shadows link 1
    send(0, 8'h22, 3, 1'b0);
    wait_idle();
    local_addr = 8'h44;
    chk(err == 1'b0, "R5", "err after matched packets", int'(err), 0);

    cur_req = "R10";
    send(0, 8'h22, 0, 1'b0);
    send(2, 8'h44, 0, 1'b1);
    wait_idle();

    cur_req = "R13";
    drv_q[0].push_back({1'b1, 2'd0, 6'd0});
    send(0, 8'h33, 2, 1'b0);
    wait_idle();

    cur_req = "R5";
    send(1, 8'h99, 3, 1'b0);
    send(2, 8'h33, 2, 1'b0);  // own address counts as unmatched
    wait_idle();
    chk(err == 1'b1, "R5", "err after unmatched header", int'(err), 1);
    chk(irq == 1'b0, "R6", "irq while masked", int'(irq), 0);
    mask_we = 1'b1; mask_wd = 1'b1;
    @(negedge clk);
    mask_we = 1'b0;
    #1;
    chk(irq == 1'b1, "R6", "irq after unmask", int'(irq), 1);
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    #1;
    chk(err == 1'b0, "R6", "err after clear", int'(err), 0);
    chk(irq == 1'b0, "R6", "irq after clear", int'(irq), 0);

    cur_req = "R9";  // contention under random backpressure
    stall_en = 1'b1;
    start_log.delete();
    for (int s = 0; s < NL; s++) begin
      send(s, 8'h44, 5, 1'b0);
      send(s, 8'h44, 4, 1'b1);
    end
    send(0, 8'h33, 6, 1'b0);
    send(2, 8'h22, 6, 1'b0);
    wait_idle();
    stall_en = 1'b0;
    chk(start_log.size() >= 3, "R8", "packets logged at local", start_log.size(), 3);
    if (start_log.size() >= 3)
      chk(start_log[0] != start_log[1] && start_log[1] != start_log[2] &&
          start_log[0] != start_log[2], "R8", "first three owners distinct",
          start_log[0] * 16 + start_log[1] * 4 + start_log[2], 0);

    cur_req = "R11";
    route_en = 1'b0;
    send(1, {2'b01, 6'h22}, 3, 1'b0);
    send(2, {2'b10, 6'h11}, 2, 1'b1);
    wait_idle();
    chk(err == 1'b0, "R11", "err in transparent mode", int'(err), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule